// File: doc/BRIEF.md
# Byte Arithmetic Unit with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor. Each cycle it takes an operation code, an accumulator operand and a second operand from a register or a memory byte. It returns the result, a strobe that says whether the result is to be written back, and the flag set the operation would leave behind. That next flag set is loaded into an internal flag register on the rising clock edge. A condition evaluator reads the registered flags and answers whether a selected branch, call or return condition holds.

Every operation follows its own flag rule. Add, subtract and exclusive-or rewrite all five flags. Increment and decrement rewrite every flag except carry. Compare computes the difference only for its flags and never asserts the write strobe. Complement writes the inverted accumulator and leaves every flag untouched. The no-operation code does nothing. The surrounding sequencer drives the operation code each cycle and uses the write strobe and the condition answer to steer write-back and program flow.

Top module: `alu_core`

## Requirements
- R1: While `rstN` is low, the flag register (`flagsQ`) is all zero.
- R2: Operation code 1 (add) gives `result = opA + opB` modulo 256 with `resultWe = 1`. Carry (flag bit 0) is the carry out of bit 7. Aux carry (flag bit 2) is the carry from bit 3 into bit 4.
- R3: Operation code 2 (subtract) gives `result = opA - opB` modulo 256 with `resultWe = 1`. Carry is 1 exactly when opA < opB, unsigned. Aux carry is 1 exactly when opA[3:0] < opB[3:0].
- R4: Operation code 3 (compare) sets every flag exactly as subtract would for the same operands, and holds `resultWe` at 0.
- R5: Operation codes 4 (increment) and 5 (decrement) give `opA + 1` and `opA - 1` with `resultWe = 1`, and ignore `opB`. Aux carry is the nibble carry for increment and the nibble borrow for decrement. Carry keeps its registered value.
- R6: Operation code 6 (exclusive-or) gives `opA ^ opB` with `resultWe = 1`, and clears both carry and aux carry.
- R7: Operation code 7 (complement) gives `~opA` with `resultWe = 1`, and `flagsNext` equals `flagsQ`.
- R8: For codes 1 to 6, the other flags follow the computed value. Sign (flag bit 4) equals bit 7 of that value. Zero (flag bit 3) is 1 exactly when the value is 0. Parity (flag bit 1) is 1 exactly when the value has an even number of ones.
- R9: Operation code 0 (no operation) holds `resultWe` at 0, and `flagsNext` equals `flagsQ`.
- R10: `result`, `resultWe` and `flagsNext` are combinational in the same cycle. `flagsQ` takes the value of `flagsNext` at each rising clock edge after reset.
- R11: `condTrue` tests `flagsQ` according to `condSel`. The codes are 0 for zero clear, 1 for zero set, 2 for sign clear, 3 for sign set, 4 for parity clear, 5 for parity set, 6 for carry clear and 7 for carry set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 3 | Operation code (0 nop, 1 add, 2 sub, 3 cmp, 4 inc, 5 dec, 6 xor, 7 complement) |
| opA | input | 8 | Accumulator operand |
| opB | input | 8 | Second operand |
| condSel | input | 3 | Condition code to evaluate |
| result | output | 8 | Computed value |
| resultWe | output | 1 | Result is to be written back |
| flagsNext | output | 5 | Flags after this operation {S,Z,AC,P,CY} |
| flagsQ | output | 5 | Registered flags {S,Z,AC,P,CY} |
| condTrue | output | 1 | Selected condition holds on flagsQ |

## Verification
`result`, `resultWe` and `flagsNext` are due in the same cycle the operation is presented. `flagsQ` changes one rising edge later, and `condTrue` follows `flagsQ` in that same later cycle. The bench drives inputs on the falling edge. It checks the combinational outputs 1 ns after driving. It then checks the registered flags and the condition answer 1 ns after the next rising edge, against a flag model it advances only at that edge. A flag rule that should keep the old flags is therefore compared against the model's previous state.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_CMP = 3'd3,
    OP_INC = 3'd4,
    OP_DEC = 3'd5,
    OP_XOR = 3'd6,
    OP_CPL = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_SUB = 2'd1,
    K_XOR = 2'd2,
    K_NOT = 2'd3
  } aluKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     writeRes;  // result goes back to a register
    logic     loadMain;  // update S, Z, AC, P
    logic     loadCy;    // update carry
    logic     useOne;    // second operand forced to one
    aluKind_e kind;      // function unit select
  } aluStrobe_t;

  localparam int FLAG_W = 5;
  localparam int F_S  = 4;
  localparam int F_Z  = 3;
  localparam int F_AC = 2;
  localparam int F_P  = 1;
  localparam int F_CY = 0;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobe_t  strobe
);

  aluOp_e op;
  assign op = aluOp_e'(opSel);

  always_comb begin
    strobe = '{writeRes: 1'b0, loadMain: 1'b0, loadCy: 1'b0,
               useOne: 1'b0, kind: K_ADD};
    unique case (op)
      OP_NOP: ;
      OP_ADD: begin
        strobe.writeRes = 1'b1;
        strobe.loadMain = 1'b1;
        strobe.loadCy   = 1'b1;
      end
      OP_SUB: begin
        strobe.writeRes = 1'b1;
        strobe.loadMain = 1'b1;
        strobe.loadCy   = 1'b1;
        strobe.kind     = K_SUB;
      end
      OP_CMP: begin
        strobe.loadMain = 1'b1;
        strobe.loadCy   = 1'b1;
        strobe.kind     = K_SUB;
      end
      OP_INC: begin
        strobe.writeRes = 1'b1;
        strobe.loadMain = 1'b1;
        strobe.useOne   = 1'b1;
      end
      OP_DEC: begin
        strobe.writeRes = 1'b1;
        strobe.loadMain = 1'b1;
        strobe.useOne   = 1'b1;
        strobe.kind     = K_SUB;
      end
      OP_XOR: begin
        strobe.writeRes = 1'b1;
        strobe.loadMain = 1'b1;
        strobe.loadCy   = 1'b1;
        strobe.kind     = K_XOR;
      end
      OP_CPL: begin
        strobe.writeRes = 1'b1;
        strobe.kind     = K_NOT;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [DW-1:0]     opA,
  input  logic [DW-1:0]     opB,
  input  logic [2:0]        condSel,
  output logic [DW-1:0]     result,
  output logic              resultWe,
  output logic [FLAG_W-1:0] flagsNext,
  output logic [FLAG_W-1:0] flagsQ,
  output logic              condTrue
);

  localparam int HALF = DW / 2;

  logic [DW-1:0] bOp;
  logic [DW:0]   wideVal;
  logic [HALF:0] lowVal;
  logic [DW-1:0] resVal;
  logic          cyVal;
  logic          acVal;

  assign bOp = strobe.useOne ? DW'(1) : opB;

  // single adder shared by add, subtract, compare, increment, decrement
  always_comb begin
    wideVal = '0;
    lowVal  = '0;
    resVal  = '0;
    cyVal   = 1'b0;
    acVal   = 1'b0;
    unique case (strobe.kind)
      K_ADD: begin
        wideVal = {1'b0, opA} + {1'b0, bOp};
        lowVal  = {1'b0, opA[HALF-1:0]} + {1'b0, bOp[HALF-1:0]};
        resVal  = wideVal[DW-1:0];
        cyVal   = wideVal[DW];
        acVal   = lowVal[HALF];
      end
      K_SUB: begin
        wideVal = {1'b0, opA} - {1'b0, bOp};
        lowVal  = {1'b0, opA[HALF-1:0]} - {1'b0, bOp[HALF-1:0]};
        resVal  = wideVal[DW-1:0];
        cyVal   = wideVal[DW];    // borrow
        acVal   = lowVal[HALF];   // nibble borrow
      end
      K_XOR: resVal = opA ^ opB;
      K_NOT: resVal = ~opA;
      default: ;
    endcase
  end

  always_comb begin
    flagsNext = flagsQ;
    if (strobe.loadMain) begin
      flagsNext[F_S]  = resVal[DW-1];
      flagsNext[F_Z]  = (resVal == '0);
      flagsNext[F_P]  = ~^resVal;
      flagsNext[F_AC] = acVal;
    end
    if (strobe.loadCy) flagsNext[F_CY] = cyVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsNext;
  end

  assign result   = resVal;
  assign resultWe = strobe.writeRes;

  // condition: sel[2:1] picks the flag, sel[0] the polarity wanted
  logic pickFlag;
  always_comb begin
    unique case (condSel[2:1])
      2'd0: pickFlag = flagsQ[F_Z];
      2'd1: pickFlag = flagsQ[F_S];
      2'd2: pickFlag = flagsQ[F_P];
      default: pickFlag = flagsQ[F_CY];
    endcase
  end

  assign condTrue = condSel[0] ? pickFlag : ~pickFlag;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opSel,
  input  logic [DW-1:0]     opA,
  input  logic [DW-1:0]     opB,
  input  logic [2:0]        condSel,
  output logic [DW-1:0]     result,
  output logic              resultWe,
  output logic [FLAG_W-1:0] flagsNext,
  output logic [FLAG_W-1:0] flagsQ,
  output logic              condTrue
);

  aluStrobe_t strobe;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .condSel   (condSel),
    .result    (result),
    .resultWe  (resultWe),
    .flagsNext (flagsNext),
    .flagsQ    (flagsQ),
    .condTrue  (condTrue)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opSel,
  input logic [DW-1:0]     opA,
  input logic [DW-1:0]     opB,
  input logic [2:0]        condSel,
  input logic [DW-1:0]     result,
  input logic              resultWe,
  input logic [FLAG_W-1:0] flagsNext,
  input logic [FLAG_W-1:0] flagsQ,
  input logic              condTrue
);

  logic mainOp;
  assign mainOp = (opSel >= 3'd1) && (opSel <= 3'd6);

  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> flagsQ == '0);

  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'd3 |-> !resultWe);

  p_incdec_keep_cy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'd4 || opSel == 3'd5) |=> flagsQ[F_CY] == $past(flagsQ[F_CY]));

  p_xor_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'd6 |-> (!flagsNext[F_CY] && !flagsNext[F_AC]));

  p_cpl_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'd7 |=> $stable(flagsQ));

  p_szp_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    mainOp |-> (flagsNext[F_S] == result[DW-1]) && (flagsNext[F_Z] == (result == '0))
               && (flagsNext[F_P] == ~^result));

  p_nop_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'd0 |-> (!resultWe && flagsNext == flagsQ));

  p_flag_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> flagsQ == $past(flagsNext));

  p_cond_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    condSel == 3'd1 |-> condTrue == flagsQ[F_Z]);

endmodule

bind alu_core alu_core_chk #(.DW(DW)) u_chk (.*);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opSel = 3'd0;
  logic [7:0] opA = 8'd0;
  logic [7:0] opB = 8'd0;
  logic [2:0] condSel = 3'd0;
  logic [7:0] result;
  logic       resultWe;
  logic [4:0] flagsNext;
  logic [4:0] flagsQ;
  logic       condTrue;

  int checks = 0;
  int errors = 0;
  logic [4:0] flModel = 5'd0;

  always #4 clk = ~clk;

  alu_core dut_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opB(opB),
    .condSel(condSel), .result(result), .resultWe(resultWe),
    .flagsNext(flagsNext), .flagsQ(flagsQ), .condTrue(condTrue)
  );

  // returns {we, result, flags {S,Z,AC,P,CY}}
  function automatic logic [13:0] model(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [4:0] fl);
    logic [7:0] r;
    logic       we, cy, ac, updMain;
    logic [4:0] f;
    r = 8'd0; we = 1'b1; cy = fl[0]; ac = fl[2]; updMain = 1'b1;
    case (op)
      3'd0: begin we = 1'b0; updMain = 1'b0; end
      3'd1: begin r = a + b; cy = (int'(a) + int'(b)) > 255;
                  ac = (int'(a[3:0]) + int'(b[3:0])) > 15; end
      3'd2, 3'd3: begin r = a - b; cy = a < b; ac = a[3:0] < b[3:0];
                  if (op == 3'd3) we = 1'b0; end
      3'd4: begin r = a + 8'd1; ac = (a[3:0] == 4'hF); end
      3'd5: begin r = a - 8'd1; ac = (a[3:0] == 4'h0); end
      3'd6: begin r = a ^ b; cy = 1'b0; ac = 1'b0; end
      default: begin r = ~a; updMain = 1'b0; end
    endcase
    f = fl;
    if (updMain) f = {r[7], (r == 8'd0), ac, ~^r, cy};
    return {we, r, f};
  endfunction

  function automatic logic condModel(input logic [2:0] s, input logic [4:0] fl);
    logic v;
    case (s[2:1])
      2'd0: v = fl[3];
      2'd1: v = fl[4];
      2'd2: v = fl[1];
      default: v = fl[0];
    endcase
    return s[0] ? v : ~v;
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R9";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic [2:0] cs);
    logic [13:0] e;
    @(negedge clk);
    opSel = op; opA = a; opB = b; condSel = cs;
    e = model(op, a, b, flModel);
    #1;
    chk(tagOf(op), "resultWe", 16'(resultWe), 16'(e[13]));
    if (e[13]) chk(tagOf(op), "result", 16'(result), 16'(e[12:5]));
    chk(tagOf(op), "flagsNext", 16'(flagsNext), 16'(e[4:0]));
    if (op >= 3'd1 && op <= 3'd6)
      chk("R8", "S/Z/P", 16'({flagsNext[4:3], flagsNext[1]}),
          16'({e[4:3], e[1]}));
    @(posedge clk);
    #1;
    flModel = e[4:0];
    chk("R10", "flagsQ", 16'(flagsQ), 16'(flModel));
    chk("R11", "condTrue", 16'(condTrue), 16'(condModel(cs, flModel)));
  endtask

  task automatic sweepCond();
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      condSel = 3'(s);
      #1;
      chk("R11", "condSweep", 16'(condTrue), 16'(condModel(3'(s), flModel)));
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "flagsQ in reset", 16'(flagsQ), 16'd0);
    chk("R1", "condTrue NZ in reset", 16'(condTrue), 16'd1);
    @(negedge clk);
    rstN = 1'b1;

    // directed corners
    doOp(3'd1, 8'h0F, 8'h01, 3'd7);   // R2 nibble carry
    doOp(3'd1, 8'hFF, 8'h01, 3'd1);   // R2 carry out, zero
    sweepCond();                       // R11 all codes
    doOp(3'd4, 8'hFF, 8'h00, 3'd7);   // R5 wrap with CY held at 1
    doOp(3'd5, 8'h00, 8'h55, 3'd6);   // R5 borrow from nibble, CY still held
    doOp(3'd2, 8'h00, 8'h01, 3'd3);   // R3 borrow, negative
    doOp(3'd3, 8'h42, 8'h42, 3'd1);   // R4 equal compare
    doOp(3'd3, 8'h10, 8'h20, 3'd7);   // R4 less than
    doOp(3'd7, 8'h5A, 8'h00, 3'd5);   // R7 flags unchanged
    doOp(3'd6, 8'hA5, 8'hA5, 3'd1);   // R6 zero, carries cleared
    doOp(3'd0, 8'h12, 8'h34, 3'd0);   // R9
    sweepCond();

    for (int i = 0; i < 600; i++)
      doOp(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom),
           3'($urandom_range(0, 7)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule